// File: doc/BRIEF.md
# Sharer invalidation fan-out sequencer

When a directory grants write ownership of a line, every other cached copy has to be cleared. This block takes the directory entry for the line, the format in which that entry is stored, and the node ID of the requester. It turns the entry into an ordered list of destinations, one per cycle, on an output with a valid/ready handshake. The ack count is published before any destination is sent, so the requester knows how many acknowledgements to expect. Delivering the messages and collecting the acks are handled elsewhere.

The entry has one of three forms. The first is an owner pointer that names a single processor. The second is a per-node presence vector. The third is a coarse vector in which each bit covers a group of `NODES/VEC_W` consecutive nodes. A destination produced from either vector form addresses both processors of its node. A destination produced from an owner pointer addresses only the processor that was named. The format is chosen per request, so the choice between the two vector forms can change at run time.

Top module: `inval_fanout_seq`

## Requirements
- R1: After synchronous reset, `out_valid`=0, `done`=0, `ack_count`=0 and `req_ready`=1.
- R2: With `req_fmt`=0 (owner pointer), `req_entry[NODE_W:0]` is a processor ID. Its node is `req_entry[NODE_W:1]` and its CPU is `req_entry[0]`. Exactly one destination is produced for that node, with `out_all_cpus`=0 and `out_cpu`=`req_entry[0]`.
- R3: With `req_fmt`=1 (node vector), each set bit `i` of `req_entry` names node `i`. Nodes at or above `VEC_W` are never named. Each destination has `out_all_cpus`=1 and `out_cpu`=0.
- R4: With `req_fmt`=2 (group vector), a set bit `g` names every node from `g*NODES/VEC_W` to `(g+1)*NODES/VEC_W-1`. Each destination has `out_all_cpus`=1.
- R5: The node given by `req_node` is never a destination, in any format, and is not counted in `ack_count`.
- R6: Destinations come out in ascending node order, one per handshake. While `out_ready` is low, `out_valid` and all destination fields hold steady.
- R7: `ack_count` is updated on the cycle after a request is accepted. It equals the number of destinations that request produces, and it holds until the next request is accepted.
- R8: `done` is a one-cycle pulse on the cycle after the last handshake. For a request with no destinations, `done` pulses on the cycle after acceptance and `out_valid` stays low.
- R9: `req_ready` is low while destinations are pending. A request presented during that time is ignored and does not disturb the stream in progress.
- R10: `req_fmt`=3 is reserved and produces no destinations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_fmt | input | 2 | Entry format: 0 owner, 1 node vector, 2 group vector, 3 reserved |
| req_entry | input | VEC_W | Directory entry |
| req_node | input | NODE_W | Requester's node ID |
| out_valid | output | 1 | Destination present |
| out_ready | input | 1 | Downstream takes the destination |
| out_node | output | NODE_W | Destination node |
| out_all_cpus | output | 1 | Destination addresses both processors of the node |
| out_cpu | output | 1 | Processor within node when `out_all_cpus` is 0 |
| ack_count | output | CNT_W | Number of destinations for the current request |
| done | output | 1 | Pulse after the final destination is taken |

## Verification
The hardest case to reach is the edge where the final destination is taken and a new request is waiting. On that edge `req_ready` is still low, and on the next cycle `done` pulses while a request may already be accepted. To reach it, the bench holds `req_valid` high during busy periods and changes `req_entry` on every stalled cycle. It also drives `out_ready` with random duty cycles from 100% down to 20%. Group-vector requests place the requester inside a set group, so only one node of that group must be dropped. The bench also applies a fully set group vector, which yields the largest count of `NODES-1`.

// File: rtl/inval_fanout_pkg.sv
`timescale 1ns/1ps
package inval_fanout_pkg;
  typedef enum logic [1:0] {
    FMT_OWNER    = 2'd0,
    FMT_NODEVEC  = 2'd1,
    FMT_GROUPVEC = 2'd2,
    FMT_RSVD     = 2'd3
  } fmt_e;
endpackage

// File: rtl/inval_target_map.sv
`timescale 1ns/1ps
module inval_target_map
  import inval_fanout_pkg::*;
#(
  parameter int NODES = 32,
  parameter int VEC_W = 16,
  localparam int NODE_W = $clog2(NODES),
  localparam int GRP = NODES / VEC_W
) (
  input  fmt_e              fmt,
  input  logic [VEC_W-1:0]  entry,
  input  logic [NODE_W-1:0] self_node,
  output logic [NODES-1:0]  mask
);
  for (genvar n = 0; n < NODES; n++) begin : g_node
    logic own_hit, vec_hit, grp_hit, sel;
    assign own_hit = (entry[NODE_W:1] == NODE_W'(n));
    if (n < VEC_W) begin : g_in
      assign vec_hit = entry[n];
    end else begin : g_out
      assign vec_hit = 1'b0;
    end
    assign grp_hit = entry[n / GRP];
    always_comb begin
      case (fmt)
        FMT_OWNER:    sel = own_hit;
        FMT_NODEVEC:  sel = vec_hit;
        FMT_GROUPVEC: sel = grp_hit;
        default:      sel = 1'b0;
      endcase
    end
    assign mask[n] = sel && (self_node != NODE_W'(n));
  end
endmodule

// File: rtl/inval_lowest.sv
`timescale 1ns/1ps
module inval_lowest #(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/inval_popcount.sv
`timescale 1ns/1ps
module inval_popcount #(
  parameter int N = 32,
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) count = count + CW'(vec[i]);
  end
endmodule

// File: rtl/inval_fanout_seq.sv
`timescale 1ns/1ps
module inval_fanout_seq
  import inval_fanout_pkg::*;
#(
  parameter int NODES = 32,
  parameter int VEC_W = 16,
  localparam int NODE_W = $clog2(NODES),
  localparam int CNT_W = $clog2(NODES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_fmt,
  input  logic [VEC_W-1:0]  req_entry,
  input  logic [NODE_W-1:0] req_node,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NODE_W-1:0] out_node,
  output logic              out_all_cpus,
  output logic              out_cpu,
  output logic [CNT_W-1:0]  ack_count,
  output logic              done
);
  fmt_e              fmt;
  logic [NODES-1:0]  new_mask, pend, pick_in;
  logic              pick_any;
  logic [NODE_W-1:0] pick_idx;
  logic [CNT_W-1:0]  new_cnt;

  assign fmt = fmt_e'(req_fmt);

  inval_target_map #(.NODES(NODES), .VEC_W(VEC_W)) u_map (
    .fmt(fmt), .entry(req_entry), .self_node(req_node), .mask(new_mask)
  );

  inval_popcount #(.N(NODES)) u_cnt (.vec(new_mask), .count(new_cnt));

  assign pick_in = out_valid ? pend : new_mask;

  inval_lowest #(.N(NODES)) u_pick (.vec(pick_in), .any(pick_any), .idx(pick_idx));

  assign req_ready = !out_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_node     <= '0;
      out_all_cpus <= 1'b0;
      out_cpu      <= 1'b0;
      ack_count    <= '0;
      done         <= 1'b0;
      pend         <= '0;
    end else begin
      done <= 1'b0;
      if (!out_valid) begin
        if (req_valid) begin
          ack_count <= new_cnt;
          if (pick_any) begin
            out_valid    <= 1'b1;
            out_node     <= pick_idx;
            pend         <= pick_in & ~(NODES'(1) << pick_idx);
            out_all_cpus <= (fmt != FMT_OWNER);
            out_cpu      <= (fmt == FMT_OWNER) ? req_entry[0] : 1'b0;
          end else begin
            done <= 1'b1;
          end
        end
      end else if (out_ready) begin
        if (pick_any) begin
          out_node <= pick_idx;
          pend     <= pick_in & ~(NODES'(1) << pick_idx);
        end else begin
          out_valid <= 1'b0;
          done      <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/inval_fanout_chk.sv
`timescale 1ns/1ps
module inval_fanout_chk #(
  parameter int NODES = 32,
  parameter int VEC_W = 16,
  localparam int NODE_W = $clog2(NODES),
  localparam int CNT_W = $clog2(NODES + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [NODE_W-1:0] req_node,
  input logic              out_valid,
  input logic              out_ready,
  input logic [NODE_W-1:0] out_node,
  input logic              out_all_cpus,
  input logic [CNT_W-1:0]  ack_count,
  input logic              done
);
  logic [NODE_W-1:0] held_node;
  always_ff @(posedge clk) begin
    if (rst) held_node <= '0;
    else if (req_valid && req_ready) held_node <= req_node;
  end

  a_r9_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !req_ready);
  a_r6_hold_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_node) && $stable(out_all_cpus)));
  a_r6_ascending: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (!out_valid || out_node > $past(out_node)));
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_valid);
  a_r5_skip_requester: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_node != held_node));
  a_r2_owner_single: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_all_cpus) |-> (ack_count == CNT_W'(1)));
  a_r7_count_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |-> $stable(ack_count));
endmodule

bind inval_fanout_seq inval_fanout_chk #(.NODES(NODES), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_node(req_node), .out_valid(out_valid), .out_ready(out_ready),
  .out_node(out_node), .out_all_cpus(out_all_cpus), .ack_count(ack_count),
  .done(done)
);

// File: tb/inval_fanout_seq_test.sv
`timescale 1ns/1ps
module inval_fanout_seq_test;
  localparam int NODES = 32;
  localparam int VEC_W = 16;
  localparam int NODE_W = $clog2(NODES);
  localparam int CNT_W = $clog2(NODES + 1);
  localparam int GRP = NODES / VEC_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_fmt = 2'd0;
  logic [VEC_W-1:0] req_entry = '0;
  logic [NODE_W-1:0] req_node = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [NODE_W-1:0] out_node;
  logic out_all_cpus, out_cpu;
  logic [CNT_W-1:0] ack_count;
  logic done;

  always #2 clk = ~clk;

  inval_fanout_seq #(.NODES(NODES), .VEC_W(VEC_W)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_fmt(req_fmt), .req_entry(req_entry), .req_node(req_node),
    .out_valid(out_valid), .out_ready(out_ready), .out_node(out_node),
    .out_all_cpus(out_all_cpus), .out_cpu(out_cpu), .ack_count(ack_count),
    .done(done)
  );

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  int rdy_pct = 100;
  bit started = 0;
  bit finished = 0;
  string tag = "R1";

  // reference model: queue of node*4 + all*2 + cpu
  int q[$];
  int m_cnt = 0;
  bit m_done = 0;

  task automatic build(input int f, input int e, input int self);
    for (int n = 0; n < NODES; n++) begin
      bit hit;
      int word;
      hit = 0;
      word = 0;
      if (f == 0) begin
        hit = ((e & ((1 << (NODE_W + 1)) - 1)) / 2) == n;
        word = n * 4 + (e & 1);
      end else if (f == 1) begin
        hit = (n < VEC_W) && (((e >> n) & 1) == 1);
        word = n * 4 + 2;
      end else if (f == 2) begin
        hit = ((e >> (n / GRP)) & 1) == 1;
        word = n * 4 + 2;
      end
      if (hit && n != self) q.push_back(word);
    end
  endtask

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      q.delete();
      m_cnt = 0;
      m_done = 0;
    end else begin
      m_done = 0;
      if (q.size() > 0) begin
        if (out_ready) begin
          void'(q.pop_front());
          if (q.size() == 0) m_done = 1;
        end
      end else if (req_valid) begin
        build(int'(req_fmt), int'(req_entry), int'(req_node));
        m_cnt = q.size();
        if (q.size() == 0) m_done = 1;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s/%s %s: got %0d expected %0d at cycle %0d", req, tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      check("R9", "req_ready", int'(req_ready), int'(q.size() == 0));
      check("R6", "out_valid", int'(out_valid), int'(q.size() > 0));
      check("R7", "ack_count", int'(ack_count), m_cnt);
      check("R8", "done", int'(done), int'(m_done));
      if (q.size() > 0 && out_valid)
        check("R6", "dest", int'(out_node) * 4 + int'(out_all_cpus) * 2 + int'(out_cpu), q[0]);
    end
    out_ready = ($urandom_range(99) < rdy_pct);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog expired: got %0d expected %0d", cyc, 100000);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic issue(input int f, input int e, input int self, input bit wait_idle);
    bit r;
    if (wait_idle) begin
      do @(negedge clk); while (!req_ready);
    end else begin
      @(negedge clk);
    end
    req_valid = 1'b1;
    req_fmt = 2'(f);
    req_entry = VEC_W'(e);
    req_node = NODE_W'(self);
    forever begin
      r = req_ready;
      @(negedge clk);
      if (r) break;
      req_entry = VEC_W'($urandom);   // changes while busy must be ignored (R9)
    end
    req_valid = 1'b0;
  endtask

  task automatic drain();
    do @(negedge clk); while (!req_ready);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    tag = "R1";
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    tag = "R2";
    issue(0, 13, 3, 1); drain();           // node 6, cpu 1
    tag = "R5";
    issue(0, 12, 6, 1); drain();           // owner is the requester: none
    tag = "R3";
    issue(1, 16'hA5A5, 0, 1); drain();
    tag = "R5";
    issue(1, 16'hFFFF, 7, 1); drain();
    tag = "R4";
    issue(2, 16'h8001, 31, 1); drain();    // nodes 0,1,30
    issue(2, 16'hFFFF, 10, 1); drain();    // NODES-1 targets
    tag = "R10";
    issue(3, 16'hFFFF, 2, 1); drain();
    tag = "R8";
    issue(1, 16'h0000, 4, 1); drain();
    issue(1, 16'h0003, 1, 1);               // single target then zero-target back to back
    issue(1, 16'h0000, 1, 0); drain();

    tag = "R6";
    rdy_pct = 40;
    issue(2, 16'h0F0F, 9, 1); drain();
    tag = "R9";
    for (int i = 0; i < 300; i++) begin
      rdy_pct = 20 + (i % 5) * 20;
      issue($urandom_range(3), $urandom, $urandom_range(NODES - 1), 0);
    end
    drain();

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule